// File: doc/BRIEF.md
# Power-Mode Sequencer

This block decides which low-power state a small microcontroller core is in, and from that state it sets up the clock and pad controls. It watches two instruction strobes (sleep-to-standby and sleep-to-stop), three mode flags and a set of wake-up requests. From these it moves between six modes: reset, active, subactive, standby, watch and stop. In each mode it drives the main oscillator enable, a run enable and a source select for each of the three clock domains (CPU, time-base, peripherals), and the pad controls for output hold, output high impedance and input enable.

The block contains the two cycle-clock dividers. Each oscillator is presented as a one-cycle pulse in the block's clock domain. The main pulse train is divided by four and the sub pulse train by eight. For each domain, a per-domain tick output then combines its run enable, its source select and the matching divided pulse. Mode changes land on the clock edge that samples a strobe or wake request. All control outputs come straight from flops, so the gating they drive cannot glitch. The flags are `tmr_sel` (timer-mode select), `slow_on` (stay on the slow clock) and `direct_on` (skip the watch detour). They are plain level inputs owned by software elsewhere, and this block never writes them. The interface has no data stream, so no valid/ready handshake is involved.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is 0 (reset), the main oscillator is enabled, all three domain run enables are 0, pads are high impedance and inputs are disabled. On the first clock edge after release, `mode` becomes 1 (active).
- R2: The main cycle pulse occurs once every 4 main oscillator pulses, and only while the main oscillator is enabled. The sub cycle pulse occurs once every 8 sub oscillator pulses. A domain tick is present only when that domain runs, and it follows its selected source: select 0 means main, 1 means sub.
- R3: In active mode (code 1), the main oscillator is on, all three domains run from the main source, inputs are enabled, and pads neither hold nor float.
- R4: In active mode, either strobe with `slow_on`=1 moves to subactive mode (code 2).
- R5: In active mode, the standby strobe alone with `slow_on`=0 moves to standby (code 3). In standby the main oscillator is on, the CPU is stopped, the peripherals run from main, and the time-base runs with its select equal to `tmr_sel`.
- R6: Standby returns to active on `int0_req` or on any bit of `other_req`. A time-base request alone leaves it in standby.
- R7: In active mode, the stop strobe with `slow_on`=0 and `tmr_sel`=0 moves to stop (code 5). In stop, the oscillator and all domains are off and pads are high impedance. Only reset leaves stop: strobes and all wake requests are ignored.
- R8: In active mode, the stop strobe with `slow_on`=0 and `tmr_sel`=1 moves to watch (code 4). In watch, only the time-base runs, from the sub source, and the main oscillator is off.
- R9: Watch is left on `int0_req` or `tbase_req`, going to subactive if `slow_on`=1 and to active otherwise. Requests on `other_req` are ignored.
- R10: In subactive mode, the main oscillator is off and all three domains run from the sub source.
- R11: In subactive mode, either strobe goes straight to active when `slow_on`=0 and `direct_on`=1, and to watch otherwise.
- R12: Output hold is 1 only in standby and watch, pads are high impedance only in stop and reset, and inputs are enabled only in active and subactive.
- R13: When both strobes arrive together in active mode, the stop strobe decides the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces reset mode |
| main_osc_pulse | input | 1 | One pulse per main oscillator period |
| sub_osc_pulse | input | 1 | One pulse per sub oscillator period |
| sby_op | input | 1 | Standby instruction strobe |
| stop_op | input | 1 | Stop instruction strobe |
| tmr_sel | input | 1 | Timer-mode select flag |
| slow_on | input | 1 | Low-speed-on flag |
| direct_on | input | 1 | Direct-transfer-on flag |
| int0_req | input | 1 | External interrupt 0 request |
| tbase_req | input | 1 | Time-base interrupt request |
| other_req | input | NOTHER | Timer, serial and INT1 requests |
| mode | output | 3 | Current mode code |
| main_osc_en | output | 1 | Main oscillator enable |
| cpu_run | output | 1 | CPU domain run enable |
| cpu_sel_sub | output | 1 | CPU domain uses sub source |
| cpu_tick | output | 1 | CPU domain clock enable pulse |
| tb_run | output | 1 | Time-base domain run enable |
| tb_sel_sub | output | 1 | Time-base domain uses sub source |
| tb_tick | output | 1 | Time-base clock enable pulse |
| per_run | output | 1 | Peripheral domain run enable |
| per_sel_sub | output | 1 | Peripheral domain uses sub source |
| per_tick | output | 1 | Peripheral clock enable pulse |
| out_hold | output | 1 | Outputs keep their last value |
| pins_hiz | output | 1 | Outputs high impedance |
| in_en | output | 1 | Input buffers enabled |

## Verification
The assertions check, on every cycle, that stop is sticky and that the standby, watch and direct subactive exits happen on the next edge. They also check that subactive never uses the main source, that no domain tick appears without its run enable, and that the pad controls stay consistent with the mode. The bench scenarios are the only place to see the full target mode for every flag and strobe combination. They also show the exact divide ratios through tick counts, the time-base source in standby, and that ignored requests really leave the mode unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_RESET   = 3'd0,
    M_ACTIVE  = 3'd1,
    M_SUBACT  = 3'd2,
    M_STANDBY = 3'd3,
    M_WATCH   = 3'd4,
    M_STOP    = 3'd5
  } pmode_e;

  typedef struct packed {
    logic osc;
    logic cpu_run;
    logic cpu_sub;
    logic tb_run;
    logic tb_sub;
    logic per_run;
    logic per_sub;
    logic hold;
    logic hiz;
    logic in_en;
  } pctl_t;

  function automatic pctl_t ctl_of(pmode_e m, logic tsel);
    pctl_t c;
    c = '0;
    case (m)
      M_RESET: begin
        c.osc = 1'b1;
        c.hiz = 1'b1;
      end
      M_ACTIVE: begin
        c.osc     = 1'b1;
        c.cpu_run = 1'b1;
        c.tb_run  = 1'b1;
        c.per_run = 1'b1;
        c.in_en   = 1'b1;
      end
      M_SUBACT: begin
        c.cpu_run = 1'b1;
        c.cpu_sub = 1'b1;
        c.tb_run  = 1'b1;
        c.tb_sub  = 1'b1;
        c.per_run = 1'b1;
        c.per_sub = 1'b1;
        c.in_en   = 1'b1;
      end
      M_STANDBY: begin
        c.osc     = 1'b1;
        c.tb_run  = 1'b1;
        c.tb_sub  = tsel;
        c.per_run = 1'b1;
        c.hold    = 1'b1;
      end
      M_WATCH: begin
        c.tb_run = 1'b1;
        c.tb_sub = 1'b1;
        c.hold   = 1'b1;
      end
      M_STOP: begin
        c.hiz = 1'b1;
      end
      default: c.hiz = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lpm_cycdiv.sv
module lpm_cycdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic osc_pulse,
  output logic cyc_pulse
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (osc_pulse) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cyc_pulse = run && osc_pulse && (cnt_q == LAST);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int NOTHER = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sby_op,
  input  logic              stop_op,
  input  logic              tmr_sel,
  input  logic              slow_on,
  input  logic              direct_on,
  input  logic              int0_req,
  input  logic              tbase_req,
  input  logic [NOTHER-1:0] other_req,
  output pmode_e            mode_q,
  output pmode_e            mode_nxt
);
  logic strobe, sby_wake, wch_wake;

  assign strobe   = sby_op || stop_op;
  assign sby_wake = int0_req || (|other_req);
  assign wch_wake = int0_req || tbase_req;

  always_comb begin
    mode_nxt = mode_q;
    case (mode_q)
      M_RESET:  mode_nxt = M_ACTIVE;
      M_ACTIVE: begin
        if (strobe) begin
          if (slow_on)      mode_nxt = M_SUBACT;
          else if (stop_op) mode_nxt = tmr_sel ? M_WATCH : M_STOP;
          else              mode_nxt = M_STANDBY;
        end
      end
      M_STANDBY: if (sby_wake) mode_nxt = M_ACTIVE;
      M_WATCH:   if (wch_wake) mode_nxt = slow_on ? M_SUBACT : M_ACTIVE;
      M_SUBACT: begin
        if (strobe) mode_nxt = (!slow_on && direct_on) ? M_ACTIVE : M_WATCH;
      end
      M_STOP:   mode_nxt = M_STOP;
      default:  mode_nxt = M_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_RESET;
    else        mode_q <= mode_nxt;
  end
endmodule

// File: rtl/lpm_ctlreg.sv
module lpm_ctlreg
  import lpm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pmode_e mode_nxt,
  input  logic   tmr_sel,
  output pctl_t  ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= ctl_of(M_RESET, 1'b0);
    else        ctl_q <= ctl_of(mode_nxt, tmr_sel);
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NOTHER   = 5,
  parameter int MAIN_DIV = 4,
  parameter int SUB_DIV  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_osc_pulse,
  input  logic              sub_osc_pulse,
  input  logic              sby_op,
  input  logic              stop_op,
  input  logic              tmr_sel,
  input  logic              slow_on,
  input  logic              direct_on,
  input  logic              int0_req,
  input  logic              tbase_req,
  input  logic [NOTHER-1:0] other_req,
  output logic [2:0]        mode,
  output logic              main_osc_en,
  output logic              cpu_run,
  output logic              cpu_sel_sub,
  output logic              cpu_tick,
  output logic              tb_run,
  output logic              tb_sel_sub,
  output logic              tb_tick,
  output logic              per_run,
  output logic              per_sel_sub,
  output logic              per_tick
  ,
  output logic              out_hold,
  output logic              pins_hiz,
  output logic              in_en
);
  localparam int NDOM = 3;

  pmode_e mode_q, mode_nxt;
  pctl_t  ctl_q;
  logic   main_cyc, sub_cyc;
  logic [NDOM-1:0] dom_run, dom_sub, dom_tick;

  lpm_seq #(.NOTHER(NOTHER)) u_seq (
    .clk(clk), .rst_n(rst_n), .sby_op(sby_op), .stop_op(stop_op),
    .tmr_sel(tmr_sel), .slow_on(slow_on), .direct_on(direct_on),
    .int0_req(int0_req), .tbase_req(tbase_req), .other_req(other_req),
    .mode_q(mode_q), .mode_nxt(mode_nxt)
  );

  lpm_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_nxt(mode_nxt), .tmr_sel(tmr_sel), .ctl_q(ctl_q)
  );

  lpm_cycdiv #(.DIV(MAIN_DIV)) u_main_div (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.osc), .osc_pulse(main_osc_pulse), .cyc_pulse(main_cyc)
  );

  lpm_cycdiv #(.DIV(SUB_DIV)) u_sub_div (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .osc_pulse(sub_osc_pulse), .cyc_pulse(sub_cyc)
  );

  assign dom_run = {ctl_q.per_run, ctl_q.tb_run, ctl_q.cpu_run};
  assign dom_sub = {ctl_q.per_sub, ctl_q.tb_sub, ctl_q.cpu_sub};

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    assign dom_tick[d] = dom_run[d] && (dom_sub[d] ? sub_cyc : main_cyc);
  end

  assign mode        = mode_q;
  assign main_osc_en = ctl_q.osc;
  assign cpu_run     = dom_run[0];
  assign cpu_sel_sub = dom_sub[0];
  assign cpu_tick    = dom_tick[0];
  assign tb_run      = dom_run[1];
  assign tb_sel_sub  = dom_sub[1];
  assign tb_tick     = dom_tick[1];
  assign per_run     = dom_run[2];
  assign per_sel_sub = dom_sub[2];
  assign per_tick    = dom_tick[2];
  assign out_hold    = ctl_q.hold;
  assign pins_hiz    = ctl_q.hiz;
  assign in_en       = ctl_q.in_en;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NOTHER = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sby_op,
  input logic              stop_op,
  input logic              slow_on,
  input logic              direct_on,
  input logic              int0_req,
  input logic              tbase_req,
  input logic [NOTHER-1:0] other_req,
  input logic [2:0]        mode,
  input logic              main_osc_en,
  input logic              cpu_run,
  input logic              cpu_sel_sub,
  input logic              cpu_tick,
  input logic              tb_sel_sub,
  input logic              per_sel_sub,
  input logic              out_hold,
  input logic              pins_hiz,
  input logic              in_en
);
  p_stop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 |=> mode == 3'd5);

  p_standby_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && (int0_req || (|other_req))) |=> mode == 3'd1);

  p_watch_to_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && (int0_req || tbase_req) && slow_on) |=> mode == 3'd2);

  p_watch_to_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && (int0_req || tbase_req) && !slow_on) |=> mode == 3'd1);

  p_sub_direct_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && (sby_op || stop_op) && !slow_on && direct_on) |=> mode == 3'd1);

  p_sub_slow_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd2 |-> (!main_osc_en && cpu_sel_sub && tb_sel_sub && per_sel_sub));

  p_tick_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tick |-> cpu_run);

  p_inputs_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_en |-> (mode == 3'd1 || mode == 3'd2));

  p_hold_not_float_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_hold |-> (!pins_hiz && !in_en));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NOTHER(NOTHER)) u_chk (
  .clk(clk), .rst_n(rst_n), .sby_op(sby_op), .stop_op(stop_op),
  .slow_on(slow_on), .direct_on(direct_on), .int0_req(int0_req),
  .tbase_req(tbase_req), .other_req(other_req), .mode(mode),
  .main_osc_en(main_osc_en), .cpu_run(cpu_run), .cpu_sel_sub(cpu_sel_sub),
  .cpu_tick(cpu_tick), .tb_sel_sub(tb_sel_sub), .per_sel_sub(per_sel_sub),
  .out_hold(out_hold), .pins_hiz(pins_hiz), .in_en(in_en)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
  localparam int NOTHER = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_osc_pulse = 1'b1, sub_osc_pulse = 1'b1;
  logic sby_op = 1'b0, stop_op = 1'b0;
  logic tmr_sel = 1'b0, slow_on = 1'b0, direct_on = 1'b0;
  logic int0_req = 1'b0, tbase_req = 1'b0;
  logic [NOTHER-1:0] other_req = '0;
  logic [2:0] mode;
  logic main_osc_en, cpu_run, cpu_sel_sub, cpu_tick, tb_run, tb_sel_sub, tb_tick;
  logic per_run, per_sel_sub, per_tick, out_hold, pins_hiz, in_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpm_ctrl #(.NOTHER(NOTHER)) i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .main_osc_pulse(main_osc_pulse), .sub_osc_pulse(sub_osc_pulse),
    .sby_op(sby_op), .stop_op(stop_op), .tmr_sel(tmr_sel), .slow_on(slow_on),
    .direct_on(direct_on), .int0_req(int0_req), .tbase_req(tbase_req), .other_req(other_req),
    .mode(mode), .main_osc_en(main_osc_en), .cpu_run(cpu_run), .cpu_sel_sub(cpu_sel_sub),
    .cpu_tick(cpu_tick), .tb_run(tb_run), .tb_sel_sub(tb_sel_sub), .tb_tick(tb_tick),
    .per_run(per_run), .per_sel_sub(per_sel_sub), .per_tick(per_tick),
    .out_hold(out_hold), .pins_hiz(pins_hiz), .in_en(in_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // {osc, cpu_run, cpu_sub, tb_run, tb_sub, per_run, per_sub, hold, hiz, in_en}
  function automatic logic [9:0] exp_ctl(int m, bit t);
    case (m)
      0: return 10'b1_000000_010;
      1: return 10'b1_101010_001;
      2: return 10'b0_111111_001;
      3: return {1'b1, 1'b0, 1'b0, 1'b1, t, 1'b1, 1'b0, 3'b100};
      4: return 10'b0_001100_100;
      default: return 10'b0_000000_010;
    endcase
  endfunction

  function automatic logic [9:0] act_ctl();
    return {main_osc_en, cpu_run, cpu_sel_sub, tb_run, tb_sel_sub, per_run, per_sel_sub,
            out_hold, pins_hiz, in_en};
  endfunction

  task automatic chk_state(input int m, input string req);
    check(mode == 3'(m), req, int'(mode), m);
    check(act_ctl() == exp_ctl(m, tmr_sel), {req, " controls"}, int'(act_ctl()),
          int'(exp_ctl(m, tmr_sel)));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk_state(0, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk_state(1, "R1 exit / R3 active");
  endtask

  task automatic strobe(input bit s, input bit p);
    @(negedge clk); sby_op = s; stop_op = p;
    @(negedge clk); sby_op = 1'b0; stop_op = 1'b0;
  endtask

  task automatic wake(input bit i0, input bit tb, input logic [NOTHER-1:0] oth);
    @(negedge clk); int0_req = i0; tbase_req = tb; other_req = oth;
    @(negedge clk); int0_req = 1'b0; tbase_req = 1'b0; other_req = '0;
  endtask

  task automatic count_ticks(input int n, output int c, output int t, output int p);
    c = 0; t = 0; p = 0;
    repeat (n) begin
      @(negedge clk);
      c += int'(cpu_tick); t += int'(tb_tick); p += int'(per_tick);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, t, p, em;
    do_reset();

    // R2: active, main source divided by 4 on every domain
    count_ticks(80, c, t, p);
    check(c == 20 && t == 20 && p == 20, "R2 main divide", c, 20);

    // Sweep of every flag set and strobe kind from active (R4 R5 R7 R8 R13)
    for (int f = 0; f < 8; f++) begin
      for (int s = 1; s < 4; s++) begin
        tmr_sel = f[0]; slow_on = f[1]; direct_on = f[2];
        do_reset();
        strobe(s[0], s[1]);
        if (f[1])      em = 2;
        else if (s[1]) em = f[0] ? 4 : 5;
        else           em = 3;
        chk_state(em, (s == 3) ? "R13 both strobes" :
                      (em == 2) ? "R4 to subactive" : (em == 3) ? "R5 to standby" :
                      (em == 4) ? "R8 to watch" : "R7 to stop");
        case (em)
          5: begin
            wake(1'b1, 1'b1, '1);
            strobe(1'b1, 1'b1);
            chk_state(5, "R7 stop ignores wakes");
          end
          3: begin
            wake(1'b0, 1'b1, '0);
            chk_state(3, "R6 standby ignores time-base");
            if (f % 6 == 5) wake(1'b1, 1'b0, '0);
            else            wake(1'b0, 1'b0, NOTHER'(1) << (f % 6));
            chk_state(1, "R6 standby wake");
          end
          4: begin
            wake(1'b0, 1'b0, '1);
            chk_state(4, "R9 watch ignores others");
            count_ticks(80, c, t, p);
            check(c == 0 && t == 10 && p == 0, "R8 R2 watch ticks", t, 10);
            slow_on = f[2];
            wake(s[0], ~s[0], '0);
            chk_state(f[2] ? 2 : 1, "R9 watch exit");
          end
          2: begin
            count_ticks(80, c, t, p);
            check(c == 10 && t == 10 && p == 10, "R10 R2 sub divide", c, 10);
          end
          default: ;
        endcase
      end
    end

    // R11: subactive exits over flag pairs and strobe kinds
    for (int f = 0; f < 4; f++) begin
      for (int s = 1; s < 4; s++) begin
        tmr_sel = 1'b0; direct_on = 1'b0; slow_on = 1'b1;
        do_reset();
        strobe(1'b1, 1'b0);
        chk_state(2, "R4 to subactive");
        slow_on = f[0]; direct_on = f[1];
        strobe(s[0], s[1]);
        em = (!f[0] && f[1]) ? 1 : 4;
        chk_state(em, "R11 subactive exit");
        if (em == 4) begin
          wake(1'b1, 1'b0, '0);
          chk_state(f[0] ? 2 : 1, "R9 R11 watch return");
        end
      end
    end

    // R2: standby with main time-base source keeps ticking on main; CPU silent
    tmr_sel = 1'b0; slow_on = 1'b0;
    do_reset();
    strobe(1'b1, 1'b0);
    count_ticks(80, c, t, p);
    check(c == 0 && t == 20 && p == 20, "R2 R12 standby ticks", t, 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule